// File: doc/BRIEF.md
# Privilege-Filtered Overflow Performance Counter

This block is one programmable hardware event counter for a processor core. Each cycle the core may raise a single-cycle count request. The block accepts it only when the counter exists, is marked available and is not globally inhibited. A per-counter event control register then decides whether the current privilege level, with or without virtualization, is excluded from counting. The count is held as one 64-bit value. A mode input selects between a plain 64-bit increment and a paired-halves scheme meant for a 32-bit core.

When the count wraps, the block sets a sticky overflow flag in the event control register. If that flag was clear before the wrap, the block also raises a local overflow interrupt request, which stays high until software clears the flag. Software reads and writes the count and the event control register as four 32-bit words. A software write always takes priority over a count request in the same cycle.

Top module: `hpm_counter`

## Requirements
- R1: After reset, both count words and both event control words read zero and `irq_o` is low.
- R2: A count request has no effect when the parameter `CTR_IDX` is below 3 or not below `MAX_CTRS`, when `avail_mask_i[CTR_IDX]` is 0, or when `inhibit_mask_i[CTR_IDX]` is 1.
- R3: In the 64-bit event control register, bit 62 blocks counting in machine mode (`priv_i`=3), bit 61 in supervisor mode (`priv_i`=1) with `virt_i`=0, bit 60 in user mode (`priv_i`=0) with `virt_i`=0, bit 59 in supervisor mode with `virt_i`=1, and bit 58 in user mode with `virt_i`=1. These are bits 30, 29, 28, 27 and 26 of the upper event word. The reserved code `priv_i`=2 never counts.
- R4: With `split_i`=0, an accepted request adds one to the 64-bit count, carrying across the halves, and all ones wraps to zero.
- R5: With `split_i`=1, an accepted request increments the low half unless it is all ones. In that case the high half is incremented and the low half stays all ones. Only when both halves are all ones does the pair wrap to zero.
- R6: On a wrap, if the overflow flag (bit 63, bit 31 of the upper event word) is clear, it is set and `irq_o` rises on the same edge. If the flag is already set, no new request is raised.
- R7: Software writes via `wr_en_i`, `wr_sel_i` and `wr_data_i` replace the addressed word on the next edge. Setting the flag by software does not raise `irq_o`. Writing the upper event word with bit 31 clear drops `irq_o`, and `irq_o` otherwise stays high.
- R8: In a cycle with `wr_en_i`=1, any count request is discarded, whichever word is written.
- R9: Word select encoding for reads and writes: 0 count low, 1 count high, 2 event low, 3 event high. `rd_data_o` shows the selected word combinationally.
- R10: Each accepted request adds exactly one, visible from the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tally_i | input | 1 | Single-cycle count request |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization active |
| split_i | input | 1 | 1 selects paired 32-bit halves counting |
| avail_mask_i | input | MAX_CTRS | Available-counter mask, one bit per counter index |
| inhibit_mask_i | input | MAX_CTRS | Global counter-inhibit mask |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 2 | Word addressed by the write |
| wr_data_i | input | HALF_W | Write data |
| rd_sel_i | input | 2 | Word addressed by the read |
| rd_data_o | output | HALF_W | Read data |
| irq_o | output | 1 | Local counter-overflow interrupt request |

## Verification
The bench walks the full matrix of privilege and virtualization against each inhibit bit, since a design that swapped the supervisor and user bits or ignored `virt_i` would count where it should stop. It drives both count modes across the all-ones boundaries. A 64-bit-only design would clear the low half in split mode, and a design with no carry would leave the high word stale. It wraps with the overflow flag clear, with the flag already set by hardware and with the flag set by software, which catches an interrupt that is raised again or one raised by a software write. It also collides writes with requests, and a design that let the request win would show an off-by-one count. A second instance with a counter index below 3 must never move.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_EVT_LO = 2'd2,
        SEL_EVT_HI = 2'd3
    } word_sel_e;

    // Control bit offsets counted down from the MSB of the event register
    localparam int OFS_OVF  = 0;
    localparam int OFS_MINH = 1;
    localparam int OFS_SINH = 2;
    localparam int OFS_UINH = 3;
    localparam int OFS_VSIN = 4;
    localparam int OFS_VUIN = 5;

    // Lowest counter index that may be programmed
    localparam int FIRST_PROG_IDX = 3;

    typedef struct packed {
        logic m_inh;
        logic s_inh;
        logic u_inh;
        logic vs_inh;
        logic vu_inh;
    } inh_bits_t;

endpackage

// File: rtl/hpm_gate.sv
module hpm_gate
    import hpm_pkg::*;
#(
    parameter int MAX_CTRS = 32,
    parameter int CTR_IDX  = 3
) (
    input  logic                tally_i,
    input  logic [1:0]          priv_i,
    input  logic                virt_i,
    input  logic [MAX_CTRS-1:0] avail_mask_i,
    input  logic [MAX_CTRS-1:0] inhibit_mask_i,
    input  inh_bits_t           inh_i,
    output logic                accept_o
);

    logic mode_block;

    always_comb begin
        unique case (priv_i)
            PRIV_M:  mode_block = inh_i.m_inh;
            PRIV_S:  mode_block = virt_i ? inh_i.vs_inh : inh_i.s_inh;
            PRIV_U:  mode_block = virt_i ? inh_i.vu_inh : inh_i.u_inh;
            default: mode_block = 1'b1;
        endcase
    end

    generate
        if (CTR_IDX < FIRST_PROG_IDX || CTR_IDX >= MAX_CTRS) begin : g_absent
            assign accept_o = 1'b0;
        end else begin : g_present
            assign accept_o = tally_i && avail_mask_i[CTR_IDX]
                              && !inhibit_mask_i[CTR_IDX] && !mode_block;
        end
    endgenerate

endmodule

// File: rtl/hpm_step.sv
module hpm_step #(
    parameter int HALF_W = 32,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic [FULL_W-1:0] cnt_i,
    input  logic              split_i,
    output logic [FULL_W-1:0] nxt_o,
    output logic              wrap_o
);

    logic [HALF_W-1:0] lo, hi;
    logic              lo_full, hi_full;

    assign lo      = cnt_i[HALF_W-1:0];
    assign hi      = cnt_i[FULL_W-1:HALF_W];
    assign lo_full = &lo;
    assign hi_full = &hi;

    always_comb begin
        nxt_o  = cnt_i;
        wrap_o = lo_full && hi_full;
        if (split_i) begin
            if (lo_full && hi_full) begin
                nxt_o = '0;
            end else if (lo_full) begin
                nxt_o = {hi + HALF_W'(1), lo};
            end else begin
                nxt_o = {hi, lo + HALF_W'(1)};
            end
        end else begin
            nxt_o = cnt_i + FULL_W'(1);
        end
    end

endmodule

// File: rtl/hpm_counter.sv
module hpm_counter
    import hpm_pkg::*;
#(
    parameter int MAX_CTRS = 32,
    parameter int CTR_IDX  = 3,
    parameter int HALF_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tally_i,
    input  logic [1:0]          priv_i,
    input  logic                virt_i,
    input  logic                split_i,
    input  logic [MAX_CTRS-1:0] avail_mask_i,
    input  logic [MAX_CTRS-1:0] inhibit_mask_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [HALF_W-1:0]   wr_data_i,
    input  logic [1:0]          rd_sel_i,
    output logic [HALF_W-1:0]   rd_data_o,
    output logic                irq_o
);

    localparam int FULL_W  = 2 * HALF_W;
    localparam int B_OVF   = FULL_W - 1 - OFS_OVF;
    localparam int B_MINH  = FULL_W - 1 - OFS_MINH;
    localparam int B_SINH  = FULL_W - 1 - OFS_SINH;
    localparam int B_UINH  = FULL_W - 1 - OFS_UINH;
    localparam int B_VSIN  = FULL_W - 1 - OFS_VSIN;
    localparam int B_VUIN  = FULL_W - 1 - OFS_VUIN;

    typedef struct packed {
        logic [FULL_W-1:0] cnt;
        logic [FULL_W-1:0] evt;
        logic              irq;
    } state_t;

    state_t state_d, state_q;

    inh_bits_t         inh;
    logic              inc_ok;
    logic [FULL_W-1:0] step_nxt;
    logic              step_wrap;

    assign inh = '{m_inh:  state_q.evt[B_MINH],
                   s_inh:  state_q.evt[B_SINH],
                   u_inh:  state_q.evt[B_UINH],
                   vs_inh: state_q.evt[B_VSIN],
                   vu_inh: state_q.evt[B_VUIN]};

    hpm_gate #(
        .MAX_CTRS(MAX_CTRS),
        .CTR_IDX (CTR_IDX)
    ) u_gate (
        .tally_i       (tally_i),
        .priv_i        (priv_i),
        .virt_i        (virt_i),
        .avail_mask_i  (avail_mask_i),
        .inhibit_mask_i(inhibit_mask_i),
        .inh_i         (inh),
        .accept_o      (inc_ok)
    );

    hpm_step #(
        .HALF_W(HALF_W)
    ) u_step (
        .cnt_i  (state_q.cnt),
        .split_i(split_i),
        .nxt_o  (step_nxt),
        .wrap_o (step_wrap)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            unique case (word_sel_e'(wr_sel_i))
                SEL_CNT_LO: state_d.cnt[HALF_W-1:0]      = wr_data_i;
                SEL_CNT_HI: state_d.cnt[FULL_W-1:HALF_W] = wr_data_i;
                SEL_EVT_LO: state_d.evt[HALF_W-1:0]      = wr_data_i;
                SEL_EVT_HI: begin
                    state_d.evt[FULL_W-1:HALF_W] = wr_data_i;
                    if (!wr_data_i[HALF_W-1]) begin
                        state_d.irq = 1'b0;
                    end
                end
                default: ;
            endcase
        end else if (inc_ok) begin
            state_d.cnt = step_nxt;
            if (step_wrap && !state_q.evt[B_OVF]) begin
                state_d.evt[B_OVF] = 1'b1;
                state_d.irq        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (word_sel_e'(rd_sel_i))
            SEL_CNT_LO: rd_data_o = state_q.cnt[HALF_W-1:0];
            SEL_CNT_HI: rd_data_o = state_q.cnt[FULL_W-1:HALF_W];
            SEL_EVT_LO: rd_data_o = state_q.evt[HALF_W-1:0];
            SEL_EVT_HI: rd_data_o = state_q.evt[FULL_W-1:HALF_W];
            default:    rd_data_o = '0;
        endcase
    end

    assign irq_o = state_q.irq;

    // Assertions

    a_r2_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_ok && !wr_en_i) |=> $stable(state_q.cnt));

    a_r3_machine_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == PRIV_M && state_q.evt[B_MINH] && !wr_en_i) |=> $stable(state_q.cnt));

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ok && !split_i && (&state_q.cnt) && !wr_en_i) |=> (state_q.cnt == '0));

    a_r5_low_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ok && split_i && (&state_q.cnt[HALF_W-1:0])
         && !(&state_q.cnt[FULL_W-1:HALF_W]) && !wr_en_i)
        |=> (&state_q.cnt[HALF_W-1:0]));

    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> state_q.evt[B_OVF]);

    a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.evt[B_OVF] && !irq_o && !wr_en_i) |=> !irq_o);

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en_i) |=> irq_o);

    a_r8_write_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i[1]) |=> $stable(state_q.cnt));

endmodule

// File: tb/hpm_counter_tb.sv
`timescale 1ns/100ps
module hpm_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tally = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic        split = 1'b0;
    logic [31:0] avail = 32'hFFFF_FFF8;
    logic [31:0] inhib = 32'h0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data, low_rd;
    logic        irq, low_irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    hpm_counter u_dut (
        .clk(clk), .rst_n(rst_n), .tally_i(tally), .priv_i(priv), .virt_i(virt),
        .split_i(split), .avail_mask_i(avail), .inhibit_mask_i(inhib),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
    );

    // Counter index below the programmable range: must never count (R2)
    hpm_counter #(.CTR_IDX(2)) u_low (
        .clk(clk), .rst_n(rst_n), .tally_i(tally), .priv_i(priv), .virt_i(virt),
        .split_i(split), .avail_mask_i(32'hFFFF_FFFF), .inhibit_mask_i(32'h0),
        .wr_en_i(1'b0), .wr_sel_i(2'd0), .wr_data_i(32'h0),
        .rd_sel_i(2'd0), .rd_data_o(low_rd), .irq_o(low_irq)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  sel;
        logic [31:0] data;
        logic        inc;
        logic [1:0]  prv;
        logic        vrt;
        logic        av;
        logic        ih;
        logic [1:0]  rsel;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    // Tags: R2 gating, R3 mode filter, R7 writes, R8 write wins, R9 read map, R10 +1
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h1,        4'd10},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h2,        4'd10},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h2,        4'd2},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 2'd0, 32'h2,        4'd2},
        '{1'b1, 2'd3, 32'h4000_0000, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd3, 32'h4000_0000, 4'd7},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h2,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h3,        4'd3},
        '{1'b1, 2'd3, 32'h2000_0000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd3, 32'h2000_0000, 4'd7},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h3,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h4,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h5,        4'd3},
        '{1'b1, 2'd3, 32'h0400_0000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 32'h0400_0000, 4'd7},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h5,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h6,        4'd3},
        '{1'b1, 2'd3, 32'h1000_0000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 32'h1000_0000, 4'd7},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h6,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h7,        4'd3},
        '{1'b1, 2'd3, 32'h0800_0000, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd3, 32'h0800_0000, 4'd7},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h7,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h8,        4'd3},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 32'h8,        4'd3},
        '{1'b1, 2'd0, 32'h100,       1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h100,      4'd8},
        '{1'b1, 2'd3, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h100,      4'd8},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h101,      4'd10},
        '{1'b1, 2'd1, 32'h0000_ABCD, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_ABCD, 4'd7},
        '{1'b1, 2'd2, 32'h1234_5678, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd2, 32'h1234_5678, 4'd9},
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 32'h102,      4'd10},
        '{1'b0, 2'd0, 32'h0,         1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_ABCD, 4'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] data,
                        input logic inc);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = data; tally = inc;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tally = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #0.1;
        val = rd_data;
    endtask

    task automatic load_cnt(input logic [31:0] hi, input logic [31:0] lo);
        step(1'b1, 2'd0, lo, 1'b0);
        step(1'b1, 2'd1, hi, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        for (int s = 0; s < 4; s++) begin
            peek(2'(s), v);
            check("R1 reset word", v, 32'h0);
        end
        check("R1 reset irq", {31'h0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_sel = VECS[i].sel; wr_data = VECS[i].data;
            tally = VECS[i].inc; priv = VECS[i].prv; virt = VECS[i].vrt;
            avail = VECS[i].av ? 32'hFFFF_FFF8 : 32'hFFFF_FFF0;
            inhib = VECS[i].ih ? 32'h0000_0008 : 32'h0;
            rd_sel = VECS[i].rsel;
            @(posedge clk);
            #1;
            wr_en = 1'b0; tally = 1'b0;
            n_chk++;
            if (rd_data !== VECS[i].exp) begin
                n_err++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VECS[i].req, i, rd_data, VECS[i].exp);
            end
        end

        priv = 2'd3; virt = 1'b0; avail = 32'hFFFF_FFF8; inhib = 32'h0; split = 1'b0;

        // R4/R6: 64-bit wrap with flag clear raises the request
        step(1'b1, 2'd3, 32'h0, 1'b0);
        load_cnt(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        peek(2'd0, v); check("R4 wrap low", v, 32'h0);
        peek(2'd1, v); check("R4 wrap high", v, 32'h0);
        peek(2'd3, v); check("R6 flag set", v, 32'h8000_0000);
        check("R6 irq raised", {31'h0, irq}, 32'h1);

        // R6/R7: second wrap with flag set keeps request high
        load_cnt(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        check("R7 irq held", {31'h0, irq}, 32'h1);
        peek(2'd0, v); check("R4 second wrap", v, 32'h0);

        // R7: clearing the flag drops the request
        step(1'b1, 2'd3, 32'h0, 1'b0);
        check("R7 irq cleared", {31'h0, irq}, 32'h0);

        // R6/R7: flag set by software, then wrap: no request
        step(1'b1, 2'd3, 32'h8000_0000, 1'b0);
        check("R7 sw flag no irq", {31'h0, irq}, 32'h0);
        load_cnt(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        check("R6 no new irq", {31'h0, irq}, 32'h0);
        peek(2'd0, v); check("R4 wrap flagged", v, 32'h0);

        // R4: carry from low to high in 64-bit mode
        step(1'b1, 2'd3, 32'h0, 1'b0);
        load_cnt(32'h5, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        peek(2'd0, v); check("R4 carry low", v, 32'h0);
        peek(2'd1, v); check("R4 carry high", v, 32'h6);

        // R5: split halves
        split = 1'b1;
        load_cnt(32'h5, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        peek(2'd0, v); check("R5 low stays full", v, 32'hFFFF_FFFF);
        peek(2'd1, v); check("R5 high bumped", v, 32'h6);
        load_cnt(32'h0, 32'h7);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        peek(2'd0, v); check("R5 low increments", v, 32'h8);
        peek(2'd1, v); check("R5 high unchanged", v, 32'h0);
        load_cnt(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1);
        peek(2'd0, v); check("R5 pair wrap low", v, 32'h0);
        peek(2'd1, v); check("R5 pair wrap high", v, 32'h0);
        check("R6 split wrap irq", {31'h0, irq}, 32'h1);

        // R2: counter index below 3 never moved
        check("R2 low index count", low_rd, 32'h0);
        check("R2 low index irq", {31'h0, low_irq}, 32'h0);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int s = 0; s < 4; s++) begin
            peek(2'(s), v);
            check("R1 rerun reset word", v, 32'h0);
        end
        check("R1 rerun reset irq", {31'h0, irq}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule